// File: doc/BRIEF.md
# Single-Wire Bus Enumeration Master

This block is the master side of a wired-AND single-wire bus. It discovers the 64-bit identity of every slave on that bus, one identity per pass. Each pass drives a long low reset pulse and checks for a presence reply. It then sends the search command byte F0h and resolves the identity one bit at a time, from bit 0 upward. Each bit takes three time slots. The master reads the slaves' true bit, reads their complemented bit, then writes the direction it chooses. Slaves whose bit differs from the written value drop out until the next reset.

Between passes the master keeps the position of the newest bit where it took the 0 branch at a conflict. The next pass then follows the unexplored 1 branch at that position. Software, or a sequencer, pulses `start` to begin a fresh enumeration and `next` to run each further pass. Each found identity appears on `id_out` with a one-cycle `id_valid` strobe. `all_found` rises when no unexplored branch remains. All slot and reset durations are parameters counted in clock cycles. There is one set for standard speed and one for overdrive, and `overdrive` selects between them when a pass is accepted. The line is assumed to be already synchronised into the clock domain.

Top module: `search_master`

## Requirements
- R1: After reset the block is idle (`busy`=0), the line is released (`bus_pull`=0), and `id_valid`, `all_found` and `no_dev` are 0. The line is never pulled while the block is idle.
- R2: A pass begins with `bus_pull` held high for exactly RST_LOW cycles of the selected speed. The line is sampled PRES_AT cycles after release, and a low there counts as presence.
- R3: If no presence is seen, the pass ends with `no_dev`=1 and `id_valid`=0, and no time slot follows the reset pulse.
- R4: After presence, the master writes F0h as eight write slots, bit 0 first. A 0 is written as a low of LOW0 cycles and a 1 as a low of LOW1 cycles. Every slot lasts SLOT cycles, and slots follow each other with no gap.
- R5: For each identity bit the master issues a read slot sampling the true bit, then a read slot sampling the complement, then a write slot. Read slots pull low for LOW1 cycles and sample the line at cycle SAMP of the slot, with the line already released.
- R6: If exactly one of the two read values is 1, the master writes the true value that was read.
- R7: If both reads are 0 (a conflict at 1-based position n), the master writes 1 when n equals the stored discrepancy and 0 when n is above it. When n is below it, the master writes that bit of the previous identity. The newest position where it wrote 0 at a conflict becomes the stored discrepancy at the end of the pass. In this way every pass keeps at least one slave taking part.
- R8: If both reads are 1, the pass aborts at once with `no_dev`=1 and no `id_valid`.
- R9: After the write slot of bit 63, `id_out` holds the identity (bit k is the k-th resolved bit) and `id_valid` pulses for exactly one cycle. Over an enumeration the identities come out in ascending order of their bit-reversed values.
- R10: `all_found` rises together with the `id_valid` of a pass that recorded no 0-branch conflict. While `all_found` is 1, `next` is ignored. `start` clears it and restarts from the first identity.
- R11: When `overdrive` is 1 at acceptance, all reset and slot durations of that pass use the overdrive parameter set.
- R12: `start` and `next` are ignored while `busy` is 1. A `start` issued during a pass does not disturb the walk of the tree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new enumeration (clears discrepancy and done) |
| next | input | 1 | Run the next search pass |
| overdrive | input | 1 | Select the overdrive timing set for the accepted pass |
| bus_in | input | 1 | Synchronised line level, 1 = high |
| bus_pull | output | 1 | 1 = drive the line low |
| busy | output | 1 | A pass is in progress |
| id_out | output | 64 | Identity found by the latest pass |
| id_valid | output | 1 | One-cycle strobe at the end of a good pass |
| all_found | output | 1 | No unexplored branch remains |
| no_dev | output | 1 | Missing presence or no slave taking part |

## Verification
Some properties are checked on every cycle. The line must stay released while the block is idle and at the sampling point of every read slot. `id_valid` must be a single-cycle pulse that never coincides with `no_dev`. `all_found` may only rise with an identity, and `no_dev` may only rise when the pass ends. Other behaviours can only be shown by the bench's behavioural slaves. These are the choice of branch at each conflict, the order in which identities are found, the reset and slot lengths at both speeds, the command byte, and the handling of requests made while busy or after completion. The slaves drop out on each written bit and report when none is left taking part.

// File: rtl/search_master.sv
module search_master #(
  parameter int ID_BITS      = 64,
  parameter int STD_RST_LOW  = 48,
  parameter int STD_PRES_AT  = 8,
  parameter int STD_RST_LEN  = 40,
  parameter int STD_SLOT     = 12,
  parameter int STD_LOW0     = 8,
  parameter int STD_LOW1     = 1,
  parameter int STD_SAMP     = 4,
  parameter int OD_RST_LOW   = 24,
  parameter int OD_PRES_AT   = 4,
  parameter int OD_RST_LEN   = 20,
  parameter int OD_SLOT      = 8,
  parameter int OD_LOW0      = 5,
  parameter int OD_LOW1      = 1,
  parameter int OD_SAMP      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               next,
  input  logic               overdrive,
  input  logic               bus_in,
  output logic               bus_pull,
  output logic               busy,
  output logic [ID_BITS-1:0] id_out,
  output logic               id_valid,
  output logic               all_found,
  output logic               no_dev
);
  localparam int PB = $clog2(ID_BITS);
  localparam int PW = $clog2(ID_BITS + 1);
  localparam int M1 = (STD_RST_LOW > STD_RST_LEN) ? STD_RST_LOW : STD_RST_LEN;
  localparam int M2 = (OD_RST_LOW > OD_RST_LEN) ? OD_RST_LOW : OD_RST_LEN;
  localparam int CW = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam logic [7:0] CMD = 8'hF0;

  typedef enum logic [1:0] {S_IDLE, S_RLOW, S_RWAIT, S_SLOT} st_t;
  st_t st;

  logic [CW-1:0]      cnt;
  logic               od, cmd_ph, rb_t, rb_c, pres;
  logic [PB-1:0]      pos;
  logic [1:0]         sub;
  logic [ID_BITS-1:0] rom;
  logic [PW-1:0]      last_disc, last_zero;

  wire [CW-1:0] t_rlow = od ? CW'(OD_RST_LOW - 1) : CW'(STD_RST_LOW - 1);
  wire [CW-1:0] t_pres = od ? CW'(OD_PRES_AT)     : CW'(STD_PRES_AT);
  wire [CW-1:0] t_rlen = od ? CW'(OD_RST_LEN - 1) : CW'(STD_RST_LEN - 1);
  wire [CW-1:0] t_slot = od ? CW'(OD_SLOT - 1)    : CW'(STD_SLOT - 1);
  wire [CW-1:0] t_low0 = od ? CW'(OD_LOW0)        : CW'(STD_LOW0);
  wire [CW-1:0] t_low1 = od ? CW'(OD_LOW1)        : CW'(STD_LOW1);
  wire [CW-1:0] t_samp = od ? CW'(OD_SAMP)        : CW'(STD_SAMP);

  wire [PW-1:0] n        = PW'(pos) + PW'(1);
  wire          conflict = !rb_t && !rb_c;
  wire          dir      = conflict ? ((n < last_disc) ? rom[pos] : (n == last_disc)) : rb_t;
  wire [PW-1:0] zero_nx  = (conflict && !dir) ? n : last_zero;
  wire          is_write = cmd_ph || (sub == 2'd2);
  wire          wbit     = cmd_ph ? CMD[pos[2:0]] : dir;
  wire [CW-1:0] low_len  = (is_write && !wbit) ? t_low0 : t_low1;

  assign busy     = (st != S_IDLE);
  assign bus_pull = (st == S_RLOW) || ((st == S_SLOT) && (cnt < low_len));
  assign id_out   = rom;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; od <= 1'b0; cmd_ph <= 1'b0; pos <= '0; sub <= '0;
      rb_t <= 1'b0; rb_c <= 1'b0; pres <= 1'b0; rom <= '0;
      last_disc <= '0; last_zero <= '0;
      id_valid <= 1'b0; all_found <= 1'b0; no_dev <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      case (st)
        S_IDLE: if (start || (next && !all_found)) begin
          od <= overdrive; no_dev <= 1'b0; pres <= 1'b0; cnt <= '0; st <= S_RLOW;
          if (start) begin last_disc <= '0; all_found <= 1'b0; end
        end
        S_RLOW: if (cnt == t_rlow) begin cnt <= '0; st <= S_RWAIT; end
                else cnt <= cnt + 1'b1;
        S_RWAIT: begin
          if (cnt == t_pres) pres <= !bus_in;
          if (cnt == t_rlen) begin
            cnt <= '0;
            if (!pres) begin no_dev <= 1'b1; st <= S_IDLE; end
            else begin
              st <= S_SLOT; cmd_ph <= 1'b1; pos <= '0; sub <= '0; last_zero <= '0;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_SLOT: begin
          if (!is_write && cnt == t_samp) begin
            if (sub == 2'd0) rb_t <= bus_in;
            else             rb_c <= bus_in;
          end
          if (cnt == t_slot) begin
            cnt <= '0;
            if (cmd_ph) begin
              if (pos == PB'(7)) begin cmd_ph <= 1'b0; pos <= '0; end
              else pos <= pos + 1'b1;
            end else if (sub == 2'd0) sub <= 2'd1;
            else if (sub == 2'd1) begin
              if (rb_t && rb_c) begin no_dev <= 1'b1; st <= S_IDLE; end
              else sub <= 2'd2;
            end else begin
              rom[pos]  <= dir;
              last_zero <= zero_nx;
              sub       <= 2'd0;
              if (pos == PB'(ID_BITS - 1)) begin
                st        <= S_IDLE;
                id_valid  <= 1'b1;
                last_disc <= zero_nx;
                all_found <= (zero_nx == '0);
              end else pos <= pos + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_pull);
  p_nodev_ends_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_dev) |-> !busy);
  p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT && !is_write && cnt == t_samp) |-> !bus_pull);
  p_abort_no_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    no_dev |-> !id_valid);
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);
  p_done_with_id_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_found) |-> id_valid);
endmodule

// File: tb/tb_search_master.sv
module tb_search_master;
  localparam int S_RL = 48, S_PA = 8, S_RN = 40, S_SL = 12, S_L0 = 8, S_L1 = 1, S_SP = 4;
  localparam int O_RL = 24, O_PA = 4, O_RN = 20, O_SL = 8,  O_L0 = 5, O_L1 = 1, O_SP = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, next = 1'b0, overdrive = 1'b0;
  logic bus_pull, busy, id_valid, all_found, no_dev;
  logic [63:0] id_out;
  logic slave_low = 1'b0;
  wire  bus_in = !(bus_pull || slave_low);

  always #4 clk = !clk;

  search_master #(.ID_BITS(64),
    .STD_RST_LOW(S_RL), .STD_PRES_AT(S_PA), .STD_RST_LEN(S_RN), .STD_SLOT(S_SL),
    .STD_LOW0(S_L0), .STD_LOW1(S_L1), .STD_SAMP(S_SP),
    .OD_RST_LOW(O_RL), .OD_PRES_AT(O_PA), .OD_RST_LEN(O_RN), .OD_SLOT(O_SL),
    .OD_LOW0(O_L0), .OD_LOW1(O_L1), .OD_SAMP(O_SP)
  ) dut (.clk(clk), .rst_n(rst_n), .start(start), .next(next), .overdrive(overdrive),
    .bus_in(bus_in), .bus_pull(bus_pull), .busy(busy), .id_out(id_out),
    .id_valid(id_valid), .all_found(all_found), .no_dev(no_dev));

  int errors = 0, checks = 0, cyc = 0;
  logic [63:0] ids [0:7];
  bit act [0:7];
  int nid = 0;
  bit force_pres = 0, cur_od = 0, prevp = 0;
  int sidx = 999, lowlen = 0, drv = 0, t0 = 0;
  logic [7:0] cmdv = '0;
  logic [63:0] expq [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [63:0] rev(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  // Behavioural slaves on the wired-AND line, updated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
    if (rst_n) chk(busy || !bus_pull, "R1 line released while idle", 64'(bus_pull), 64'd0);
    if (drv > 0) drv--;
    if (drv == 0) slave_low = 1'b0;
    if (bus_pull && !prevp) begin
      lowlen = 1;
      if (sidx == 0) t0 = cyc;
      if (sidx == 1) chk(cyc - t0 == (cur_od ? O_SL : S_SL), "R4 R11 slot period",
                         64'(cyc - t0), 64'(cur_od ? O_SL : S_SL));
      if (sidx >= 8 && sidx < 200 && ((sidx - 8) % 3) < 2) begin
        bit any0;
        int p, k;
        any0 = 0; p = (sidx - 8) / 3; k = (sidx - 8) % 3;
        for (int i = 0; i < nid; i++)
          if (act[i] && ((k == 0) ? ids[i][p] : !ids[i][p]) == 1'b0) any0 = 1;
        if (any0) begin slave_low = 1'b1; drv = (cur_od ? O_SP : S_SP) + 1; end
      end
    end else if (bus_pull) lowlen++;
    if (!bus_pull && prevp) begin
      if (lowlen >= 20) begin
        chk(lowlen == (cur_od ? O_RL : S_RL), "R2 R11 reset low length",
            64'(lowlen), 64'(cur_od ? O_RL : S_RL));
        sidx = 0; cmdv = '0;
        for (int i = 0; i < 8; i++) act[i] = 1;
        if (nid > 0 || force_pres) begin slave_low = 1'b1; drv = (cur_od ? O_PA : S_PA) + 2; end
      end else begin
        bit b;
        b = (lowlen >= 2) ? 1'b0 : 1'b1;
        if (sidx < 8) begin
          cmdv[sidx] = b;
          if (sidx == 7) chk(cmdv == 8'hF0, "R4 command byte", 64'(cmdv), 64'hF0);
        end else if (sidx < 200 && ((sidx - 8) % 3) == 2) begin
          bit any;
          int p;
          any = 0; p = (sidx - 8) / 3;
          for (int i = 0; i < nid; i++) begin
            if (act[i] && ids[i][p] != b) act[i] = 0;
            if (act[i]) any = 1;
          end
          if (nid > 0) chk(any, "R6 R7 a slave still taking part", 64'(any), 64'd1);
        end
        sidx++;
      end
    end
    prevp = bus_pull;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic pulse_next();
    @(negedge clk); next = 1'b1; @(negedge clk); next = 1'b0;
  endtask
  task automatic wait_end();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic build_expect();
    bit used [0:7];
    expq.delete();
    for (int i = 0; i < 8; i++) used[i] = 0;
    for (int k = 0; k < nid; k++) begin
      int best;
      best = -1;
      for (int i = 0; i < nid; i++)
        if (!used[i] && (best < 0 || rev(ids[i]) < rev(ids[best]))) best = i;
      used[best] = 1;
      expq.push_back(ids[best]);
    end
  endtask

  task automatic run_enum(input bit od, input bit disturb);
    build_expect();
    overdrive = od; cur_od = od;
    pulse_start();
    for (int k = 0; k < nid; k++) begin
      if (disturb && k == 1) begin
        repeat (300) @(negedge clk);
        start = 1'b1; next = 1'b1; @(negedge clk); start = 1'b0; next = 1'b0;
      end
      wait_end();
      chk(id_valid, "R9 id_valid at pass end", 64'(id_valid), 64'd1);
      chk(id_out == expq[k], "R7 R9 R12 identity order", id_out, expq[k]);
      chk(all_found == (k == nid - 1), "R10 all_found", 64'(all_found), 64'(k == nid - 1));
      chk(!no_dev, "R6 no abort with slaves", 64'(no_dev), 64'd0);
      @(negedge clk);
      chk(!id_valid, "R9 single-cycle strobe", 64'(id_valid), 64'd0);
      if (k < nid - 1) pulse_next();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !bus_pull && !id_valid && !all_found && !no_dev, "R1 reset state",
        {59'd0, busy, bus_pull, id_valid, all_found, no_dev}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: empty bus, no presence
    nid = 0; force_pres = 0;
    pulse_start(); wait_end();
    chk(no_dev, "R3 no presence flag", 64'(no_dev), 64'd1);
    chk(!id_valid, "R3 no identity", 64'(id_valid), 64'd0);
    chk(sidx == 0, "R3 no slots after reset", 64'(sidx), 64'd0);

    // R8: presence but nobody answers reads
    force_pres = 1;
    pulse_start(); wait_end();
    chk(no_dev, "R8 abort flag", 64'(no_dev), 64'd1);
    chk(!id_valid, "R8 no identity", 64'(id_valid), 64'd0);
    chk(sidx == 10, "R8 stops after complement read", 64'(sidx), 64'd10);
    force_pres = 0;

    // single slave: one pass finishes the enumeration
    nid = 1; ids[0] = 64'hA55A_0000_1357_9B01;
    run_enum(1'b0, 1'b0);

    // four slaves, standard speed, requests injected while busy (R12)
    nid = 4;
    ids[0] = 64'h3C00_0000_1234_5601;
    ids[1] = 64'hBC00_0000_1234_5601;
    ids[2] = 64'h7100_0000_ABCD_EF01;
    ids[3] = 64'h0200_0000_0000_0028;
    run_enum(1'b0, 1'b1);

    // R10: next ignored once everything is found
    pulse_next();
    begin
      bit woke;
      woke = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy) woke = 1; end
      chk(!woke && all_found, "R10 next ignored after done", 64'(woke), 64'd0);
    end

    // R11: overdrive timing, restart from the first identity
    nid = 5; ids[4] = 64'h3C00_0000_1234_5681;
    run_enum(1'b1, 1'b0);

    // pair differing only in the top bit
    nid = 2; ids[0] = 64'h0000_0000_0000_0001; ids[1] = 64'h8000_0000_0000_0001;
    run_enum(1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule